// File: doc/BRIEF.md
# Instruction Cache with Refill Abort on Bus Error

This block is a small read-only instruction cache. It sits between a CPU fetch port and a single-beat Wishbone classic master port. It is direct-mapped, with 16 lines of four 32-bit words. A hit answers on the cycle after the request. A miss refills the whole line with four single-beat cycles, starting at word 0 and going up in order. When the refill ends, the block answers the pending fetch from the new line.

The block's main feature is how it handles a bus error during a refill. On the first cycle that `wb_err_i` is seen, the block drops the bus cycle and leaves the refill. It marks the line as present but poisoned, and it answers the fetch with `fetch_err_o` set. Any later fetch to the poisoned line gets an error response straight away, with no new bus traffic. This stops a bad address from tying up the bus in a retry loop. The CPU is expected to redirect its fetch to an exception handler; that logic is outside this block.

The `flush_i` input clears every line in one cycle. This is the only way to retry an address that failed before.

Top module: `icache_err_fill`

## Requirements
- R1: After reset, `fetch_valid_o` and `wb_cyc_o` are low and every line is absent, so the first fetch to any address misses.
- R2: On a miss accepted at a clock edge, `wb_cyc_o` and `wb_stb_o` rise after that edge. The refill addresses the line base with word offsets 0, 1, 2, 3 in order, in address bits [3:2]. The address holds steady while no ack or err is present.
- R3: Each cycle with `wb_cyc_o`, `wb_ack_i` high and `wb_err_i` low counts as exactly one beat. With ack held permanently high, a clean refill answers five cycles after the request.
- R4: After the fourth beat of a clean refill, the block does three things on the next cycle: it drops `wb_cyc_o`, it pulses `fetch_valid_o` with `fetch_err_o` low, and it returns the requested word (offset = address bits [3:2]).
- R5: A fetch to a present, clean line (tag = address bits [31:8], index = bits [7:4]) answers one cycle after the request with the cached word and starts no bus cycle.
- R6: `wb_err_i` during a refill takes priority over ack. On the next cycle `wb_cyc_o` is low, no further beat is requested, and `fetch_valid_o` pulses with `fetch_err_o` high.
- R7: A fetch to a line whose refill failed answers one cycle after the request with `fetch_err_o` high and starts no bus cycle.
- R8: A one-cycle `flush_i` pulse makes every line absent. A later fetch to a line that was poisoned or clean refills it again.
- R9: While a refill is running, `fetch_valid_o` stays low and `fetch_req_i` is ignored. Exactly one response follows each accepted request.
- R10: A fetch whose tag differs from the stored tag at the same index misses and replaces the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Clear all line presence and error flags |
| fetch_req_i | input | 1 | Fetch request, sampled while idle |
| fetch_addr_i | input | 32 | Byte address of the fetch |
| fetch_valid_o | output | 1 | One-cycle response pulse |
| fetch_data_o | output | 32 | Fetched instruction word |
| fetch_err_o | output | 1 | Response carries a bus error |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Bus strobe |
| wb_adr_o | output | 32 | Bus byte address |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack_i | input | 1 | Bus beat acknowledge |
| wb_err_i | input | 1 | Bus error terminating the beat |

## Verification
Fetches are tried against a slave that inserts random wait states and against one that holds ack permanently high. The first shows that the address is held across waits. The second shows that each ack cycle counts as exactly one beat and that the latency is fixed. Poisoned regions put the error on each of the four beat positions. This tells an abort at the first beat apart from one after partial data, and it shows that err wins over a held-high ack. Directed repeats, tag conflicts, a request raised mid-refill and flushes tell the error-hit path apart from the refill path. A random mix then cross-checks latency, beat count, data and error against a bench model of presence, tag and error flags.

// File: rtl/icache_err_fill.sv
module icache_err_fill #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int LINES = 16,
  parameter int WORDS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush_i,
  input  logic          fetch_req_i,
  input  logic [AW-1:0] fetch_addr_i,
  output logic          fetch_valid_o,
  output logic [DW-1:0] fetch_data_o,
  output logic          fetch_err_o,
  output logic          wb_cyc_o,
  output logic          wb_stb_o,
  output logic [AW-1:0] wb_adr_o,
  input  logic [DW-1:0] wb_dat_i,
  input  logic          wb_ack_i,
  input  logic          wb_err_i
);
  localparam int LSB   = $clog2(DW/8);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = AW - IDX_W - OFF_W - LSB;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS-1);

  logic [DW-1:0]    dmem [LINES*WORDS];
  logic [TAG_W-1:0] tags [LINES];
  logic [LINES-1:0] present, poisoned;

  logic             filling;
  logic [OFF_W-1:0] beat;
  logic [AW-1:0]    miss_addr;

  wire [IDX_W-1:0] q_idx = fetch_addr_i[LSB+OFF_W +: IDX_W];
  wire [OFF_W-1:0] q_off = fetch_addr_i[LSB +: OFF_W];
  wire [TAG_W-1:0] q_tag = fetch_addr_i[AW-1 -: TAG_W];
  wire [IDX_W-1:0] m_idx = miss_addr[LSB+OFF_W +: IDX_W];
  wire [OFF_W-1:0] m_off = miss_addr[LSB +: OFF_W];
  wire [TAG_W-1:0] m_tag = miss_addr[AW-1 -: TAG_W];

  wire accept   = !filling && fetch_req_i && !flush_i;
  wire hit      = present[q_idx] && (tags[q_idx] == q_tag);
  wire beat_ok  = filling && wb_ack_i && !wb_err_i;
  wire fill_end = filling && (wb_err_i || (wb_ack_i && beat == LAST));

  assign wb_cyc_o = filling;
  assign wb_stb_o = filling;
  assign wb_adr_o = {miss_addr[AW-1:LSB+OFF_W], beat, {LSB{1'b0}}};

  always_ff @(posedge clk) begin
    if (beat_ok) dmem[{m_idx, beat}] <= wb_dat_i;
    if (fill_end) tags[m_idx] <= m_tag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      present  <= '0;
      poisoned <= '0;
    end else begin
      if (flush_i) begin
        present  <= '0;
        poisoned <= '0;
      end
      if (fill_end) begin
        present[m_idx]  <= 1'b1;
        poisoned[m_idx] <= wb_err_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filling       <= 1'b0;
      beat          <= '0;
      miss_addr     <= '0;
      fetch_valid_o <= 1'b0;
      fetch_err_o   <= 1'b0;
      fetch_data_o  <= '0;
    end else begin
      fetch_valid_o <= 1'b0;
      fetch_err_o   <= 1'b0;
      if (!filling) begin
        if (accept) begin
          if (hit) begin
            fetch_valid_o <= 1'b1;
            fetch_err_o   <= poisoned[q_idx];
            fetch_data_o  <= poisoned[q_idx] ? '0 : dmem[{q_idx, q_off}];
          end else begin
            filling   <= 1'b1;
            beat      <= '0;
            miss_addr <= fetch_addr_i;
          end
        end
      end else if (wb_err_i) begin
        filling       <= 1'b0;
        fetch_valid_o <= 1'b1;
        fetch_err_o   <= 1'b1;
        fetch_data_o  <= '0;
      end else if (wb_ack_i) begin
        beat <= beat + 1'b1;
        if (beat == LAST) begin
          filling       <= 1'b0;
          fetch_valid_o <= 1'b1;
          fetch_data_o  <= (m_off == LAST) ? wb_dat_i : dmem[{m_idx, m_off}];
        end
      end
    end
  end

  p_start_word0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_cyc_o) |-> wb_adr_o[LSB +: OFF_W] == '0);

  p_beat_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && wb_ack_i && !wb_err_i && wb_adr_o[LSB +: OFF_W] != LAST)
    |=> wb_cyc_o && wb_adr_o[LSB +: OFF_W] == OFF_W'($past(wb_adr_o[LSB +: OFF_W]) + 1'b1));

  p_wait_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && !wb_ack_i && !wb_err_i) |=> wb_cyc_o && $stable(wb_adr_o));

  p_last_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && wb_ack_i && !wb_err_i && wb_adr_o[LSB +: OFF_W] == LAST)
    |=> !wb_cyc_o && fetch_valid_o && !fetch_err_o);

  p_hit_quick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wb_cyc_o && fetch_req_i && !flush_i) |=> fetch_valid_o || wb_cyc_o);

  p_err_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_cyc_o && wb_err_i) |=> !wb_cyc_o && fetch_valid_o && fetch_err_o);

  p_quiet_fill_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cyc_o |-> !fetch_valid_o);

  p_stb_cyc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wb_stb_o |-> wb_cyc_o);
endmodule

// File: tb/icache_err_fill_tb.sv
`timescale 1ns/1ps
module icache_err_fill_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        flush = 0;
  logic        req = 0;
  logic [31:0] addr = '0;
  logic        rsp_v, rsp_e;
  logic [31:0] rsp_d;
  logic        cyc, stb;
  logic [31:0] adr;
  logic [31:0] sdat = '0;
  logic        sack = 0, serr = 0;

  icache_err_fill dut_i (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .fetch_req_i(req), .fetch_addr_i(addr),
    .fetch_valid_o(rsp_v), .fetch_data_o(rsp_d), .fetch_err_o(rsp_e),
    .wb_cyc_o(cyc), .wb_stb_o(stb), .wb_adr_o(adr),
    .wb_dat_i(sdat), .wb_ack_i(sack), .wb_err_i(serr));

  always #2 clk = ~clk;

  int nchk = 0, nfail = 0;
  bit done = 0;
  bit hold_ack = 0;
  int wcnt = 0;
  int beats = 0;
  bit err_prev = 0;
  logic [31:0] exp_base = '0;

  logic [23:0] mtag [16];
  bit          mval [16];
  bit          merr [16];

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hA5C3, a[31:16] ^ a[15:0]} ^ 32'h1357_0000;
  endfunction

  function automatic bit bad(input logic [31:0] a);
    return a[13] && (a[3:2] == a[15:14]);
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (hold_ack) begin
      sack = 1'b1;
      serr = cyc && bad(adr);
    end else if (!cyc) begin
      sack = 1'b0;
      serr = 1'b0;
    end else if (wcnt == 0) begin
      serr = bad(adr);
      sack = !serr;
      wcnt = $urandom % 3;
    end else begin
      sack = 1'b0;
      serr = 1'b0;
      wcnt--;
    end
    sdat = mem_word(adr);
  end

  always @(posedge clk) begin
    if (rst_n) begin
      if (err_prev) chk(!cyc, "R6", "cyc after err", 32'(cyc), 0);
      err_prev = cyc && serr;
      if (cyc && sack && !serr) begin
        chk(adr == exp_base + 32'(beats * 4), "R2", "beat address", adr, exp_base + 32'(beats * 4));
        beats++;
      end
    end
  end

  task automatic flush_all();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
    for (int i = 0; i < 16; i++) begin mval[i] = 0; merr[i] = 0; end
  endtask

  task automatic fetch(input logic [31:0] a, input bit intrude, input string rq);
    logic [3:0]  ix = a[7:4];
    bit          h = mval[ix] && mtag[ix] == a[31:8];
    bit          e_err;
    int          e_beats, lat, k;
    bit          cyc_seen;
    if (h) begin
      e_err = merr[ix];
      e_beats = 0;
    end else begin
      k = 4;
      for (int w = 0; w < 4; w++)
        if (k == 4 && bad({a[31:4], 2'(w), 2'b00})) k = w;
      e_err = (k < 4);
      e_beats = k;
      mval[ix] = 1; merr[ix] = e_err; mtag[ix] = a[31:8];
    end
    exp_base = {a[31:4], 4'b0};
    @(negedge clk);
    beats = 0; cyc_seen = 0; lat = 0;
    req = 1; addr = a;
    do begin
      @(negedge clk);
      lat++;
      req = intrude && lat == 1 && !h;
      if (req) addr = a ^ 32'h2000;
      if (cyc) cyc_seen = 1;
    end while (!rsp_v && lat < 200);
    req = 0;
    chk(rsp_v, rq, "response seen", 32'(rsp_v), 1);
    chk(rsp_e == e_err, rq, "error flag", 32'(rsp_e), 32'(e_err));
    if (!e_err) chk(rsp_d == mem_word(a), rq, "data", rsp_d, mem_word(a));
    chk(beats == e_beats, rq, "beat count", 32'(beats), 32'(e_beats));
    if (h) begin
      chk(lat == 1, rq, "hit latency", 32'(lat), 1);
      chk(!cyc_seen, rq, "no bus on hit", 32'(cyc_seen), 0);
    end else if (hold_ack) begin
      chk(lat == 2 + (e_err ? k : 3), "R3", "held-ack latency", 32'(lat), 32'(2 + (e_err ? k : 3)));
    end
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(!rsp_v && !cyc, "R9", "quiet after response", {30'b0, rsp_v, cyc}, 0);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1CAC4E));
    for (int i = 0; i < 16; i++) begin mval[i] = 0; merr[i] = 0; mtag[i] = '0; end
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!rsp_v && !cyc, "R1", "reset outputs", {30'b0, rsp_v, cyc}, 0);

    fetch(32'h0000_0104, 0, "R1");
    fetch(32'h0000_0108, 0, "R5");
    fetch(32'h0000_010C, 0, "R4");
    fetch(32'h0000_2020, 0, "R6");
    fetch(32'h0000_2024, 0, "R7");
    fetch(32'h0000_A030, 0, "R6");
    fetch(32'h0000_A038, 0, "R7");
    hold_ack = 1;
    fetch(32'h0000_0350, 0, "R3");
    fetch(32'h0000_035C, 0, "R5");
    fetch(32'h0000_6340, 0, "R6");
    fetch(32'h0000_E060, 0, "R6");
    hold_ack = 0;
    fetch(32'h0000_0504, 0, "R10");
    fetch(32'h0000_0104, 0, "R10");
    fetch(32'h0000_0470, 1, "R9");
    fetch(32'h0000_2470, 0, "R9");
    flush_all();
    fetch(32'h0000_2020, 0, "R8");
    fetch(32'h0000_0350, 0, "R8");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r = $urandom;
      logic [31:0] a = '0;
      a[15:13] = r[15:13];
      a[7:2]   = r[7:2];
      hold_ack = r[20];
      if (r[31:27] == 0) flush_all();
      fetch(a, r[22:21] == 0, "R4");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule